// File: doc/BRIEF.md
# Systolic Command Sequencer with Skewed Bank Addressing

This block runs one multiply-accumulate command for an attached 8x8 weight-stationary processing array. A command carries four operands: where the input matrix A starts, where the accumulator rows C start (read and then overwritten in place), one scalar weight value handed to the array, and the number of A rows. Once accepted, the sequencer streams A into the array column by column. Each column has its own memory bank, and bank k runs k cycles behind bank 0, so every row reaches the array as a diagonal wavefront. Alongside it, the sequencer fetches whole C rows through a single wide port.

The array returns one partial result per lane per row. The sequencer collects these results in a small row staging store. It writes a C row back in one wide access only once all eight lanes of that row have arrived. Completion is reported on its own timeline: `busy` stays high and further commands are refused until the last row has been written, and then `done` pulses for one cycle. Software has to wait for that pulse before it reads C.

Top module: `sysarr_cmd_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy`, `done`, `c_rd_en`, `c_wr_en` and every bit of `a_rd_en` are low.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. Let t be the number of cycles since that edge, with t=0 in the first cycle after it. Bank k (lane k, address bits [k*16 +: 16]) is enabled only when 0 <= t-k < height, and it then reads address a_base + (t-k)*8 + k, modulo 2^16.
- R3: The C row port reads row r in cycle t=r, at address c_base + r modulo 2^10, once for each r from 0 to height-1, and at no other time.
- R4: Bank data returns one cycle after the read. `arr_a_valid[k]` and lane k of `arr_a_data` present it in that cycle. Bit r*8+k of `pe_mask` equals `arr_a_valid[k]` for every r. `arr_b_val` holds the command's weight while the command is active.
- R5: Lane k of each C row (bits [k*8 +: 8]) is written with the k-th lane result of that row. A row is written only after all eight of its lane results have arrived.
- R6: A command writes exactly `height` rows, in increasing row order, to c_base + row modulo 2^10, and writes nothing while the sequencer is idle.
- R7: `done` is high for exactly one cycle: the cycle after the last C row write. `busy` is high from the cycle after acceptance through the `done` cycle, and low otherwise.
- R8: A `cmd_valid` pulse while `busy` is high is ignored. The running command's addresses, written data and row count are unchanged, and no further command starts.
- R9: A command with height zero raises `done` in cycle t=0 and makes no bank, C read or C write access.
- R10: The C row data returns one cycle after the read and is presented on `arr_c_data`, with `arr_c_valid` high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_a_base | input | 16 | Start address of matrix A |
| cmd_c_base | input | 10 | Start row address of C (input and output) |
| cmd_b_val | input | 8 | Weight value for the array |
| cmd_height | input | 8 | Number of A rows |
| busy | output | 1 | Command in progress, new commands refused |
| done | output | 1 | One-cycle completion pulse |
| a_rd_en | output | 8 | Per-bank read enable for A |
| a_rd_addr | output | 128 | Per-bank read address, 16 bits per lane |
| a_rd_data | input | 64 | Per-bank read data, 8 bits per lane |
| c_rd_en | output | 1 | C row read enable |
| c_rd_addr | output | 10 | C row read address |
| c_rd_data | input | 64 | C row read data |
| c_wr_en | output | 1 | C row write enable |
| c_wr_addr | output | 10 | C row write address |
| c_wr_data | output | 64 | C row write data |
| arr_b_val | output | 8 | Weight value to the array |
| arr_a_valid | output | 8 | Per-lane A element valid to the array |
| arr_a_data | output | 64 | Per-lane A elements to the array |
| arr_c_valid | output | 1 | C input row valid to the array |
| arr_c_data | output | 64 | C input row to the array |
| pe_mask | output | 64 | Per-PE active mask, bit r*8+k |
| arr_res_valid | input | 8 | Per-lane result valid from the array |
| arr_res_data | input | 64 | Per-lane results from the array |

## Verification
Commands are issued with heights of 0, 1, 5, 8 and 20, each with its own A base, C base and weight, and the expected C rows are worked out from the bank and row contents. A height of one exercises the diagonal with a single entry per lane. The longer heights keep several rows in staging at once, which shows whether slots are reused in the right order. Bases chosen near the top of the address range make both the A and the C addresses wrap, so dropped carries show up. Height zero and a command pulsed in the middle of a run separate the immediate-completion path from the refusal path. Two commands issued back to back show whether the row and lane counters are cleared between commands.

// File: rtl/sysarr_ctl_pkg.sv
package sysarr_ctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/sysarr_a_addr.sv
module sysarr_a_addr #(
  parameter int LANES    = 8,
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int HW       = 8,
  parameter int A_STRIDE = 8,
  localparam int TW      = HW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [TW-1:0]         t_cnt,
  input  logic [HW-1:0]         height,
  input  logic [AW-1:0]         base,
  input  logic [LANES*DW-1:0]   bank_data,
  output logic [LANES-1:0]      rd_en,
  output logic [LANES*AW-1:0]   rd_addr,
  output logic [LANES-1:0]      lane_valid,
  output logic [LANES*DW-1:0]   lane_data,
  output logic [LANES*LANES-1:0] mask
);
  logic [LANES-1:0] lane_valid_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [TW-1:0] k_c;
    logic [TW-1:0] rel;
    logic [AW-1:0] rel_w;
    assign k_c   = TW'(k);
    assign rel   = t_cnt - k_c;
    assign rel_w = AW'(rel);
    assign rd_en[k] = active && (t_cnt >= k_c) && (rel < {1'b0, height});
    assign rd_addr[k*AW +: AW] = base + rel_w * AW'(A_STRIDE) + AW'(k);

    if (k > 0) begin : g_skew
      // Lane k trails lane k-1 by exactly one cycle (R2).
      assert_lane_skew_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en[k] |-> $past(rd_en[k-1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_valid_q <= '0;
    else        lane_valid_q <= rd_en;
  end

  assign lane_valid = lane_valid_q;
  assign lane_data  = bank_data;

  for (genvar r = 0; r < LANES; r++) begin : g_mrow
    assign mask[r*LANES +: LANES] = lane_valid_q;
  end

  // Forwarded lane data lines up with the bank read one cycle earlier (R4).
  assert_fwd_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lane_valid == $past(rd_en)));
endmodule

// File: rtl/sysarr_c_stage.sv
module sysarr_c_stage #(
  parameter int LANES = 8,
  parameter int CW    = 10,
  parameter int DW    = 8,
  parameter int HW    = 8,
  parameter int SLOTS = 16,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [HW-1:0]       height,
  input  logic [CW-1:0]       c_base,
  input  logic [LANES-1:0]    res_valid,
  input  logic [LANES*DW-1:0] res_data,
  output logic                wr_en,
  output logic [CW-1:0]       wr_addr,
  output logic [LANES*DW-1:0] wr_data,
  output logic                wr_last
);
  logic [LANES*DW-1:0] dat_q [SLOTS];
  logic [LANES-1:0]    vld_q [SLOTS];
  logic [LANES-1:0]    vld_n [SLOTS];
  logic [HW-1:0]       lrow_q [LANES];
  logic [HW-1:0]       lrow_n [LANES];
  logic [HW-1:0]       wrow_q, wrow_n;
  logic [SW-1:0]       cur;

  assign cur     = wrow_q[SW-1:0];
  assign wr_en   = &vld_q[cur];
  assign wr_addr = c_base + CW'(wrow_q);
  assign wr_data = dat_q[cur];
  assign wr_last = (wrow_q == (height - 1'b1));

  always_comb begin
    for (int s = 0; s < SLOTS; s++) vld_n[s] = vld_q[s];
    for (int k = 0; k < LANES; k++) lrow_n[k] = lrow_q[k];
    wrow_n = wrow_q;
    if (start) begin
      for (int s = 0; s < SLOTS; s++) vld_n[s] = '0;
      for (int k = 0; k < LANES; k++) lrow_n[k] = '0;
      wrow_n = '0;
    end else begin
      if (wr_en) begin
        vld_n[cur] = '0;
        wrow_n     = wrow_q + 1'b1;
      end
      for (int k = 0; k < LANES; k++) begin
        if (res_valid[k]) begin
          vld_n[lrow_q[k][SW-1:0]][k] = 1'b1;
          lrow_n[k] = lrow_q[k] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) vld_q[s] <= '0;
      for (int k = 0; k < LANES; k++) lrow_q[k] <= '0;
      wrow_q <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) vld_q[s] <= vld_n[s];
      for (int k = 0; k < LANES; k++) lrow_q[k] <= lrow_n[k];
      wrow_q <= wrow_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (res_valid[k]) dat_q[lrow_q[k][SW-1:0]][k*DW +: DW] <= res_data[k*DW +: DW];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // A lane result never lands on a slot bit still waiting for write-back (R5).
    assert_no_slot_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid[k] |-> !vld_q[lrow_q[k][SW-1:0]][k]);
  end

  // Rows leave in strictly increasing order (R6).
  assert_row_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start) |=> (wrow_q == $past(wrow_q) + 1'b1));
endmodule

// File: rtl/sysarr_cmd_ctrl.sv
module sysarr_cmd_ctrl
  import sysarr_ctl_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int AW       = 16,
  parameter int CW       = 10,
  parameter int DW       = 8,
  parameter int HW       = 8,
  parameter int A_STRIDE = 8,
  parameter int SLOTS    = 16,
  localparam int TW      = HW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [AW-1:0]           cmd_a_base,
  input  logic [CW-1:0]           cmd_c_base,
  input  logic [DW-1:0]           cmd_b_val,
  input  logic [HW-1:0]           cmd_height,
  output logic                    busy,
  output logic                    done,
  output logic [LANES-1:0]        a_rd_en,
  output logic [LANES*AW-1:0]     a_rd_addr,
  input  logic [LANES*DW-1:0]     a_rd_data,
  output logic                    c_rd_en,
  output logic [CW-1:0]           c_rd_addr,
  input  logic [LANES*DW-1:0]     c_rd_data,
  output logic                    c_wr_en,
  output logic [CW-1:0]           c_wr_addr,
  output logic [LANES*DW-1:0]     c_wr_data,
  output logic [DW-1:0]           arr_b_val,
  output logic [LANES-1:0]        arr_a_valid,
  output logic [LANES*DW-1:0]     arr_a_data,
  output logic                    arr_c_valid,
  output logic [LANES*DW-1:0]     arr_c_data,
  output logic [LANES*LANES-1:0]  pe_mask,
  input  logic [LANES-1:0]        arr_res_valid,
  input  logic [LANES*DW-1:0]     arr_res_data
);
  localparam logic [TW-1:0] T_SPAN = TW'(LANES);

  ctl_state_e    state_q, state_n;
  logic [TW-1:0] t_q, t_n;
  logic [AW-1:0] a_base_q, a_base_n;
  logic [CW-1:0] c_base_q, c_base_n;
  logic [DW-1:0] b_q, b_n;
  logic [HW-1:0] h_q, h_n;
  logic          c_vld_q;
  logic          accept, run, wr_last;

  assign accept = cmd_valid && (state_q == ST_IDLE);
  assign run    = (state_q == ST_RUN);

  always_comb begin
    state_n  = state_q;
    t_n      = t_q;
    a_base_n = a_base_q;
    c_base_n = c_base_q;
    b_n      = b_q;
    h_n      = h_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          a_base_n = cmd_a_base;
          c_base_n = cmd_c_base;
          b_n      = cmd_b_val;
          h_n      = cmd_height;
          t_n      = '0;
          state_n  = (cmd_height == '0) ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (t_q != (TW'(h_q) + T_SPAN)) t_n = t_q + 1'b1;
        if (c_wr_en && wr_last) state_n = ST_DONE;
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      t_q      <= '0;
      a_base_q <= '0;
      c_base_q <= '0;
      b_q      <= '0;
      h_q      <= '0;
      c_vld_q  <= 1'b0;
    end else begin
      state_q  <= state_n;
      t_q      <= t_n;
      a_base_q <= a_base_n;
      c_base_q <= c_base_n;
      b_q      <= b_n;
      h_q      <= h_n;
      c_vld_q  <= c_rd_en;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign arr_b_val = b_q;

  assign c_rd_en     = run && (t_q < TW'(h_q));
  assign c_rd_addr   = c_base_q + CW'(t_q);
  assign arr_c_valid = c_vld_q;
  assign arr_c_data  = c_rd_data;

  sysarr_a_addr #(
    .LANES(LANES), .AW(AW), .DW(DW), .HW(HW), .A_STRIDE(A_STRIDE)
  ) u_a_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (run),
    .t_cnt     (t_q),
    .height    (h_q),
    .base      (a_base_q),
    .bank_data (a_rd_data),
    .rd_en     (a_rd_en),
    .rd_addr   (a_rd_addr),
    .lane_valid(arr_a_valid),
    .lane_data (arr_a_data),
    .mask      (pe_mask)
  );

  sysarr_c_stage #(
    .LANES(LANES), .CW(CW), .DW(DW), .HW(HW), .SLOTS(SLOTS)
  ) u_c_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .height   (h_q),
    .c_base   (c_base_q),
    .res_valid(arr_res_valid),
    .res_data (arr_res_data),
    .wr_en    (c_wr_en),
    .wr_addr  (c_wr_addr),
    .wr_data  (c_wr_data),
    .wr_last  (wr_last)
  );

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  assert_wr_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |-> busy);
  assert_refuse_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && !done) |=> ($stable(a_base_q) && $stable(c_base_q) && $stable(h_q) && busy));
  assert_zero_height_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cmd_height == '0)) |=> (done && !c_rd_en && (a_rd_en == '0)));
  assert_c_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd_en |=> arr_c_valid);
endmodule

// File: tb/sysarr_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysarr_cmd_ctrl_tb_top;
  localparam int LANES = 8;
  localparam int AW = 16;
  localparam int CW = 10;
  localparam int DW = 8;
  localparam int HW = 8;
  localparam int STR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [AW-1:0] cmd_a_base = '0;
  logic [CW-1:0] cmd_c_base = '0;
  logic [DW-1:0] cmd_b_val = '0;
  logic [HW-1:0] cmd_height = '0;
  logic busy, done, c_rd_en, c_wr_en, arr_c_valid;
  logic [LANES-1:0] a_rd_en, arr_a_valid;
  logic [LANES-1:0] arr_res_valid = '0;
  logic [LANES*AW-1:0] a_rd_addr;
  logic [LANES*DW-1:0] a_rd_data = '0, c_rd_data = '0, arr_res_data = '0;
  logic [LANES*DW-1:0] c_wr_data, arr_a_data, arr_c_data;
  logic [CW-1:0] c_rd_addr, c_wr_addr;
  logic [DW-1:0] arr_b_val;
  logic [LANES*LANES-1:0] pe_mask;

  always #2.5 clk = ~clk;

  sysarr_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_a_base(cmd_a_base),
    .cmd_c_base(cmd_c_base), .cmd_b_val(cmd_b_val), .cmd_height(cmd_height),
    .busy(busy), .done(done), .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr),
    .a_rd_data(a_rd_data), .c_rd_en(c_rd_en), .c_rd_addr(c_rd_addr),
    .c_rd_data(c_rd_data), .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr),
    .c_wr_data(c_wr_data), .arr_b_val(arr_b_val), .arr_a_valid(arr_a_valid),
    .arr_a_data(arr_a_data), .arr_c_valid(arr_c_valid), .arr_c_data(arr_c_data),
    .pe_mask(pe_mask), .arr_res_valid(arr_res_valid), .arr_res_data(arr_res_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  function automatic logic [DW-1:0] fa(input int k, input logic [AW-1:0] x);
    return DW'(int'(x) * 5 + k * 3 + 1);
  endfunction
  function automatic logic [LANES*DW-1:0] crow(input logic [CW-1:0] y);
    logic [LANES*DW-1:0] v;
    for (int j = 0; j < LANES; j++) v[j*DW +: DW] = DW'(int'(y) * 7 + j * 11 + 3);
    return v;
  endfunction

  task automatic chk(input bit ok, input string rq, input string msg,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, msg, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Bank and row memories, one cycle of read latency.
  always @(posedge clk) begin
    for (int k = 0; k < LANES; k++)
      if (a_rd_en[k]) a_rd_data[k*DW +: DW] <= fa(k, a_rd_addr[k*AW +: AW]);
    if (c_rd_en) c_rd_data <= crow(c_rd_addr);
  end

  // Array model: result = C_in lane + weight * A lane, one cycle later.
  logic [LANES*DW-1:0] cin_mem [0:255];
  int cin_cnt = 0;
  int arow [LANES];
  always @(posedge clk) begin
    if (cmd_valid && !busy) begin
      cin_cnt = 0;
      for (int k = 0; k < LANES; k++) arow[k] = 0;
    end
    if (arr_c_valid) begin
      cin_mem[cin_cnt[7:0]] = arr_c_data;
      cin_cnt++;
    end
    for (int k = 0; k < LANES; k++) begin
      arr_res_valid[k] <= arr_a_valid[k];
      if (arr_a_valid[k]) begin
        arr_res_data[k*DW +: DW] <= DW'(cin_mem[arow[k][7:0]][k*DW +: DW]
                                     + arr_b_val * arr_a_data[k*DW +: DW]);
        arow[k]++;
      end
    end
  end

  // Scoreboard of expected row writes.
  logic [CW-1:0] exp_addr_q [$];
  logic [LANES*DW-1:0] exp_data_q [$];

  task automatic issue(input logic [AW-1:0] a, input logic [CW-1:0] c,
                       input logic [DW-1:0] b, input logic [HW-1:0] h);
    while (busy) @(posedge clk);
    for (int i = 0; i < int'(h); i++) begin
      logic [LANES*DW-1:0] row, cin;
      logic [CW-1:0] ca;
      ca = CW'(int'(c) + i);
      cin = crow(ca);
      for (int j = 0; j < LANES; j++)
        row[j*DW +: DW] = DW'(cin[j*DW +: DW] + b * fa(j, AW'(int'(a) + i * STR + j)));
      exp_addr_q.push_back(ca);
      exp_data_q.push_back(row);
    end
    @(posedge clk); #1;
    cmd_a_base = a; cmd_c_base = c; cmd_b_val = b; cmd_height = h; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  // Pulse a command while busy; nothing is pushed since it must be refused (R8).
  task automatic poke();
    @(posedge clk); #1;
    cmd_a_base = 16'h7777; cmd_c_base = 10'h111; cmd_b_val = 8'h55; cmd_height = 8'd3;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  // Monitor.
  bit running = 0, pending = 0;
  int t = 0, wr_cnt = 0, last_wr_t = -1, n_cmds = 0;
  logic [AW-1:0] m_a; logic [CW-1:0] m_c; logic [DW-1:0] m_b; int m_h;
  logic [LANES-1:0] p_en = '0;
  logic [AW-1:0] p_addr [LANES];
  bit p_cen = 0; logic [CW-1:0] p_caddr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_done;
      if (pending) begin
        running = 1; pending = 0; t = 0; wr_cnt = 0; last_wr_t = -1; n_cmds++;
      end else if (running) t++;

      chk(busy === running, "R7", "busy window", 64'(busy), 64'(running));
      exp_done = running && ((m_h == 0) ? (t == 0) : (wr_cnt == m_h && t == last_wr_t + 1));
      chk(done === exp_done, (m_h == 0) ? "R9" : "R7", "done timing", 64'(done), 64'(exp_done));

      for (int k = 0; k < LANES; k++) begin
        bit ee;
        ee = running && (t >= k) && (t - k < m_h);
        chk(a_rd_en[k] === ee, "R2", $sformatf("bank %0d enable t=%0d", k, t), 64'(a_rd_en[k]), 64'(ee));
        if (ee && a_rd_en[k])
          chk(a_rd_addr[k*AW +: AW] === AW'(int'(m_a) + (t - k) * STR + k), "R2",
              $sformatf("bank %0d address", k), 64'(a_rd_addr[k*AW +: AW]),
              64'(AW'(int'(m_a) + (t - k) * STR + k)));
      end
      begin
        bit ce;
        ce = running && (t < m_h);
        chk(c_rd_en === ce, "R3", "C read enable", 64'(c_rd_en), 64'(ce));
        if (ce && c_rd_en)
          chk(c_rd_addr === CW'(int'(m_c) + t), "R3", "C read address",
              64'(c_rd_addr), 64'(CW'(int'(m_c) + t)));
      end

      chk(arr_a_valid === p_en, "R4", "lane valid delay", 64'(arr_a_valid), 64'(p_en));
      chk(pe_mask === {LANES{p_en}}, "R4", "PE mask", pe_mask, {LANES{p_en}});
      for (int k = 0; k < LANES; k++)
        if (p_en[k])
          chk(arr_a_data[k*DW +: DW] === fa(k, p_addr[k]), "R4", "lane data",
              64'(arr_a_data[k*DW +: DW]), 64'(fa(k, p_addr[k])));
      if (running) chk(arr_b_val === m_b, "R4", "weight", 64'(arr_b_val), 64'(m_b));
      chk(arr_c_valid === p_cen, "R10", "C row valid delay", 64'(arr_c_valid), 64'(p_cen));
      if (p_cen) chk(arr_c_data === crow(p_caddr), "R10", "C row data", arr_c_data, crow(p_caddr));

      if (c_wr_en) begin
        chk(running, "R6", "write while idle", 64'(c_wr_en), 64'(0));
        if (exp_addr_q.size() == 0) chk(1'b0, "R6", "unexpected extra write", 64'(c_wr_addr), 64'(0));
        else begin
          logic [CW-1:0] ea; logic [LANES*DW-1:0] ed;
          ea = exp_addr_q.pop_front(); ed = exp_data_q.pop_front();
          chk(c_wr_addr === ea, "R6", "write row address", 64'(c_wr_addr), 64'(ea));
          chk(c_wr_data === ed, "R5", "write row data", c_wr_data, ed);
        end
        wr_cnt++; last_wr_t = t;
      end

      if (running && done) begin
        chk(wr_cnt == m_h, "R6", "rows written per command", 64'(wr_cnt), 64'(m_h));
        running = 0;
      end

      p_en = a_rd_en;
      for (int k = 0; k < LANES; k++) p_addr[k] = a_rd_addr[k*AW +: AW];
      p_cen = c_rd_en; p_caddr = c_rd_addr;

      if (cmd_valid && !busy) begin
        pending = 1; m_a = cmd_a_base; m_c = cmd_c_base; m_b = cmd_b_val; m_h = int'(cmd_height);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "R7", "watchdog expired", 64'(cyc), 64'(100000));
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 1'b0 && done === 1'b0 && a_rd_en === '0 && !c_rd_en && !c_wr_en,
        "R1", "outputs in reset", {a_rd_en, busy, done, c_rd_en, c_wr_en}, 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && a_rd_en === '0 && !c_rd_en && !c_wr_en,
        "R1", "outputs after release", {a_rd_en, busy, done, c_rd_en, c_wr_en}, 64'(0));

    issue(16'h0100, 10'h020, 8'd3, 8'd5);
    issue(16'h0040, 10'h000, 8'd1, 8'd1);
    issue(16'h2000, 10'h100, 8'd7, 8'd20);
    repeat (6) @(posedge clk);
    poke();
    issue(16'h0000, 10'h050, 8'd9, 8'd0);
    issue(16'hFFF0, 10'h3FC, 8'd13, 8'd8);
    issue(16'h0300, 10'h200, 8'd2, 8'd8);
    while (busy || cmd_valid) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_addr_q.size() == 0, "R6", "all expected rows written", 64'(exp_addr_q.size()), 64'(0));
    chk(n_cmds == 6, "R8", "commands started", 64'(n_cmds), 64'(6));
    summary();
  end
endmodule